// File: doc/BRIEF.md
# OAM Fault Alarm Responder

This block sits on the receive side of a cell-switching port and inspects every arriving cell for fault-management OAM traffic. It handles two flow levels. The path level covers a whole virtual path, and its cells are recognised by their VCI. The channel level covers a single virtual channel, and its cells are recognised by their PTI. An upstream connection lookup resolves each cell to a slot number. Each slot holds four latched alarm flags: path AIS, path RDI, channel AIS and channel RDI. A flag sets when a matching cell arrives. It clears after a silence of a fixed number of one-second ticks.

A programmable prescaler divides the system clock into the one-second tick. While an AIS flag is set, the block posts one RDI-return request per tick for that slot and level. The request goes out on a valid/ready stream to the cell inserter. Many AIS cells arriving within one second never produce more than one request per tick, so the pace of the return traffic is set by the tick and not by the incoming OAM rate.

Back-pressure rules: the cell input never stalls, because `cell_ready` is tied high. On the request stream, a request stays asserted with unchanged slot and level until `rdi_ready` accepts it. Requests that wait stay pending but do not multiply. A pending request is not raised a second time.

Top module: `fm_alarm_responder`

## Requirements
- R1: After reset all four flag vectors are zero, `rdi_valid` is low and `sec_tick` is low.
- R2: An accepted cell whose VCI is 3 or 4, whose OAM type nibble is 0001 and whose function nibble is 0000 (AIS) or 0001 (RDI) sets the path AIS or path RDI flag of its slot from the next cycle on.
- R3: An accepted cell whose VCI is neither 3 nor 4, whose PTI is 100 or 101, and which has the OAM type and function codes of R2 sets the matching channel AIS or channel RDI flag of its slot from the next cycle on.
- R4: A cell sets no flag and queues no request if `cell_valid` is low, if the OAM type is not 0001, if the function code is neither 0000 nor 0001, or if the VCI is not 3 or 4 and the PTI is not 100 or 101.
- R5: `sec_tick` is high for one cycle out of every `sec_div` cycles, and a value of 0 behaves as 1. Lowering `sec_div` below the current count gives a tick in the next cycle.
- R6: A set flag clears on the third tick that passes with no matching cell since the last one. A matching cell in the same cycle as a tick keeps the flag and restarts the count.
- R7: At each tick, every AIS flag that is still set after that tick's update posts one request (slot, level 0 for path and 1 for channel). A slot and level can hold at most one pending request, so there are never more handshakes than ticks for any slot and level.
- R8: `rdi_valid` with `rdi_slot` and `rdi_level` holds steady until `rdi_ready` is sampled high. When no request is held, the lowest slot goes first, and path goes before channel within a slot.
- R9: `cell_ready` is high in every cycle out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_div | input | PRE_W | Clock cycles per one-second tick |
| cell_valid | input | 1 | Cell present on the input |
| cell_ready | output | 1 | Input accepts a cell (always high) |
| cell_slot | input | SLOT_W | Connection slot from the upstream lookup |
| cell_vci | input | 16 | Header VCI |
| cell_pti | input | 3 | Header payload type |
| cell_oam_type | input | 4 | Payload OAM type nibble |
| cell_fn_type | input | 4 | Payload function nibble |
| path_ais | output | N_SLOT | Path AIS flag per slot |
| path_rdi | output | N_SLOT | Path RDI flag per slot |
| chan_ais | output | N_SLOT | Channel AIS flag per slot |
| chan_rdi | output | N_SLOT | Channel RDI flag per slot |
| sec_tick | output | 1 | One-cycle tick pulse |
| rdi_valid | output | 1 | RDI-return request present |
| rdi_ready | input | 1 | Inserter takes the request |
| rdi_slot | output | SLOT_W | Slot of the request |
| rdi_level | output | 1 | 0 path, 1 channel |

## Verification
Single AIS and RDI cells at both levels show whether the path and channel decodes are kept apart, and the silent stretch after them places the clear on the correct tick. Cells that are one code away from a valid FM cell show that the decode ignores them. A flood of AIS cells every cycle, with the inserter mostly stalled, separates a responder paced by the tick from one paced by the incoming cells, and it also exposes a request that changes while it is held. A long mixed run with changing tick periods and random back-pressure tests arbitration order and the same-cycle cases where a cell and a tick coincide.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam logic [15:0] VCI_PATH_SEG = 16'd3;
  localparam logic [15:0] VCI_PATH_E2E = 16'd4;
  localparam logic [2:0]  PTI_CHAN_SEG = 3'b100;
  localparam logic [2:0]  PTI_CHAN_E2E = 3'b101;
  localparam logic [3:0]  OAM_KIND_FM  = 4'b0001;
  localparam logic [3:0]  FN_AIS       = 4'b0000;
  localparam logic [3:0]  FN_RDI       = 4'b0001;
  localparam int          KINDS        = 4;   // path ais, path rdi, chan ais, chan rdi

  typedef enum logic {LVL_PATH = 1'b0, LVL_CHAN = 1'b1} fm_level_e;

  typedef struct packed {
    logic      hit;
    fm_level_e level;
    logic      is_rdi;
  } fm_evt_t;
endpackage

// File: rtl/fm_cell_classify.sv
module fm_cell_classify
  import fm_pkg::*;
(
  input  logic        accept,
  input  logic [15:0] vci,
  input  logic [2:0]  pti,
  input  logic [3:0]  oam_type,
  input  logic [3:0]  fn_type,
  output fm_evt_t     evt
);
  logic on_path, on_chan, fm_code, fn_known;

  always_comb begin
    on_path    = (vci == VCI_PATH_SEG) || (vci == VCI_PATH_E2E);
    on_chan    = !on_path && ((pti == PTI_CHAN_SEG) || (pti == PTI_CHAN_E2E));
    fm_code    = (oam_type == OAM_KIND_FM);
    fn_known   = (fn_type == FN_AIS) || (fn_type == FN_RDI);
    evt.hit    = accept && (on_path || on_chan) && fm_code && fn_known;
    evt.level  = on_path ? LVL_PATH : LVL_CHAN;
    evt.is_rdi = (fn_type == FN_RDI);
  end
endmodule

// File: rtl/fm_tick_gen.sv
module fm_tick_gen #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;

  always_comb begin
    limit = (div == '0) ? '0 : div - 1'b1;
    tick  = (cnt_q >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fm_alarm_table.sv
module fm_alarm_table
  import fm_pkg::*;
#(
  parameter int N_SLOT    = 4,
  parameter int SLOT_W    = 2,
  parameter int CLR_TICKS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  fm_evt_t                 evt,
  input  logic [SLOT_W-1:0]       slot,
  input  logic                    tick,
  output logic [N_SLOT*KINDS-1:0] flag_q,
  output logic [N_SLOT*2-1:0]     ais_next
);
  localparam int SIL_W = $clog2(CLR_TICKS + 1);
  localparam logic [SIL_W-1:0] SIL_LAST = SIL_W'(CLR_TICKS - 1);

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    for (genvar k = 0; k < KINDS; k++) begin : g_kind
      logic             hit, f_q, f_n;
      logic [SIL_W-1:0] s_q, s_n;

      assign hit = evt.hit && (slot == SLOT_W'(g)) &&
                   ({evt.level, evt.is_rdi} == 2'(k));

      always_comb begin
        f_n = f_q;
        s_n = s_q;
        if (hit) begin
          f_n = 1'b1;
          s_n = '0;
        end else if (tick && f_q) begin
          if (s_q == SIL_LAST) begin
            f_n = 1'b0;
            s_n = '0;
          end else begin
            s_n = s_q + 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          f_q <= 1'b0;
          s_q <= '0;
        end else begin
          f_q <= f_n;
          s_q <= s_n;
        end
      end

      assign flag_q[g*KINDS + k] = f_q;
      if ((k % 2) == 0) begin : g_ais
        assign ais_next[g*2 + k/2] = f_n;
      end
    end
  end
endmodule

// File: rtl/fm_rdi_queue.sv
module fm_rdi_queue #(
  parameter int N_REQ = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [N_REQ-1:0] ais_next,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [IDX_W-1:0] req_idx
);
  logic [N_REQ-1:0] pend_q, pend_n, clr, set;
  logic             lock_q;
  logic [IDX_W-1:0] lock_idx_q, lowest;
  logic             hs;

  always_comb begin
    lowest = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (pend_q[i]) lowest = IDX_W'(i);
    end
    req_valid = |pend_q;
    req_idx   = lock_q ? lock_idx_q : lowest;
    hs        = req_valid && req_ready;
    clr       = hs ? (N_REQ'(1) << req_idx) : '0;
    set       = tick ? ais_next : '0;
    pend_n    = (pend_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      pend_q     <= pend_n;
      lock_q     <= req_valid && !req_ready;
      lock_idx_q <= req_idx;
    end
  end
endmodule

// File: rtl/fm_alarm_responder.sv
module fm_alarm_responder
  import fm_pkg::*;
#(
  parameter int N_SLOT    = 4,
  parameter int SLOT_W    = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
  parameter int PRE_W     = 16,
  parameter int CLR_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  sec_div,
  input  logic              cell_valid,
  output logic              cell_ready,
  input  logic [SLOT_W-1:0] cell_slot,
  input  logic [15:0]       cell_vci,
  input  logic [2:0]        cell_pti,
  input  logic [3:0]        cell_oam_type,
  input  logic [3:0]        cell_fn_type,
  output logic [N_SLOT-1:0] path_ais,
  output logic [N_SLOT-1:0] path_rdi,
  output logic [N_SLOT-1:0] chan_ais,
  output logic [N_SLOT-1:0] chan_rdi,
  output logic              sec_tick,
  output logic              rdi_valid,
  input  logic              rdi_ready,
  output logic [SLOT_W-1:0] rdi_slot,
  output logic              rdi_level
);
  localparam int N_REQ = N_SLOT * 2;
  localparam int IDX_W = SLOT_W + 1;

  fm_evt_t                 evt;
  logic [N_SLOT*KINDS-1:0] flags;
  logic [N_REQ-1:0]        ais_next;
  logic [IDX_W-1:0]        req_idx;

  assign cell_ready = 1'b1;

  fm_cell_classify u_classify (
    .accept   (cell_valid && cell_ready),
    .vci      (cell_vci),
    .pti      (cell_pti),
    .oam_type (cell_oam_type),
    .fn_type  (cell_fn_type),
    .evt      (evt)
  );

  fm_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .div   (sec_div),
    .tick  (sec_tick)
  );

  fm_alarm_table #(.N_SLOT(N_SLOT), .SLOT_W(SLOT_W), .CLR_TICKS(CLR_TICKS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .slot     (cell_slot),
    .tick     (sec_tick),
    .flag_q   (flags),
    .ais_next (ais_next)
  );

  fm_rdi_queue #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sec_tick),
    .ais_next  (ais_next),
    .req_ready (rdi_ready),
    .req_valid (rdi_valid),
    .req_idx   (req_idx)
  );

  assign rdi_slot  = req_idx[IDX_W-1:1];
  assign rdi_level = req_idx[0];

  for (genvar g = 0; g < N_SLOT; g++) begin : g_out
    assign path_ais[g] = flags[g*KINDS + 0];
    assign path_rdi[g] = flags[g*KINDS + 1];
    assign chan_ais[g] = flags[g*KINDS + 2];
    assign chan_rdi[g] = flags[g*KINDS + 3];
  end
endmodule

// File: rtl/fm_alarm_responder_chk.sv
module fm_alarm_responder_chk #(
  parameter int N_SLOT = 4,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cell_valid,
  input logic              cell_ready,
  input logic [SLOT_W-1:0] cell_slot,
  input logic [15:0]       cell_vci,
  input logic [2:0]        cell_pti,
  input logic [3:0]        cell_oam_type,
  input logic [3:0]        cell_fn_type,
  input logic [N_SLOT-1:0] path_ais,
  input logic [N_SLOT-1:0] path_rdi,
  input logic [N_SLOT-1:0] chan_ais,
  input logic [N_SLOT-1:0] chan_rdi,
  input logic              sec_tick,
  input logic              rdi_valid,
  input logic              rdi_ready,
  input logic [SLOT_W-1:0] rdi_slot,
  input logic              rdi_level
);
  logic [4*N_SLOT-1:0] all_flags;
  logic                vci_path;
  assign all_flags = {path_ais, path_rdi, chan_ais, chan_rdi};
  assign vci_path  = (cell_vci == 16'd3) || (cell_vci == 16'd4);

  a_r9_input_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cell_ready);

  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (rdi_valid && !rdi_ready) |=> (rdi_valid && $stable(rdi_slot) && $stable(rdi_level)));

  a_r2_path_ais_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && cell_ready && vci_path && cell_oam_type == 4'b0001 &&
     cell_fn_type == 4'b0000) |=> path_ais[$past(cell_slot)]);

  a_r3_chan_rdi_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && cell_ready && !vci_path && cell_pti inside {3'b100, 3'b101} &&
     cell_oam_type == 4'b0001 && cell_fn_type == 4'b0001) |=> chan_rdi[$past(cell_slot)]);

  a_r6_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(all_flags) & ~all_flags)) |-> $past(sec_tick));

  a_r7_request_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdi_valid) |-> $past(sec_tick));
endmodule

bind fm_alarm_responder fm_alarm_responder_chk #(.N_SLOT(N_SLOT), .SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/test_fm_alarm_responder.sv
module test_fm_alarm_responder;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int SW = 2;
  localparam int CLR = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   sec_div = 16'd16;
  logic          cell_valid = 1'b0;
  logic          cell_ready;
  logic [SW-1:0] cell_slot = '0;
  logic [15:0]   cell_vci = '0;
  logic [2:0]    cell_pti = '0;
  logic [3:0]    cell_oam_type = '0;
  logic [3:0]    cell_fn_type = '0;
  logic [NS-1:0] path_ais, path_rdi, chan_ais, chan_rdi;
  logic          sec_tick, rdi_valid, rdi_level;
  logic          rdi_ready = 1'b1;
  logic [SW-1:0] rdi_slot;

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_alarm_responder #(.N_SLOT(NS), .CLR_TICKS(CLR)) i_fm_alarm_responder (
    .clk(clk), .rst_n(rst_n), .sec_div(sec_div),
    .cell_valid(cell_valid), .cell_ready(cell_ready), .cell_slot(cell_slot),
    .cell_vci(cell_vci), .cell_pti(cell_pti), .cell_oam_type(cell_oam_type),
    .cell_fn_type(cell_fn_type), .path_ais(path_ais), .path_rdi(path_rdi),
    .chan_ais(chan_ais), .chan_rdi(chan_rdi), .sec_tick(sec_tick),
    .rdi_valid(rdi_valid), .rdi_ready(rdi_ready), .rdi_slot(rdi_slot),
    .rdi_level(rdi_level)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // reference state: kind 0 path ais, 1 path rdi, 2 chan ais, 3 chan rdi
  int m_flag [NS][4];
  int m_sil  [NS][4];
  int m_pend [2*NS];
  int m_lock, m_lock_idx, m_tcnt;
  int n_tick, n_hs;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int exp_tick();
    int lim = (sec_div == 0) ? 0 : int'(sec_div) - 1;
    return (m_tcnt >= lim) ? 1 : 0;
  endfunction

  function automatic int exp_idx();
    if (m_lock != 0) return m_lock_idx;
    for (int i = 0; i < 2*NS; i++) if (m_pend[i] != 0) return i;
    return 0;
  endfunction

  function automatic int any_pend();
    for (int i = 0; i < 2*NS; i++) if (m_pend[i] != 0) return 1;
    return 0;
  endfunction

  task automatic step(input bit v, input int slot, input int vci, input int pti,
                      input int oam, input int fn, input bit rdy);
    int tk, vld, idx, hs, lvl, isr, hit;
    #1;
    vectors++;
    tk  = exp_tick();
    vld = any_pend();
    idx = exp_idx();
    chk(sec_tick == tk[0], "R5", "sec_tick", sec_tick, tk);
    chk(cell_ready == 1'b1, "R9", "cell_ready", cell_ready, 1);
    chk(rdi_valid == vld[0], "R7", "rdi_valid", rdi_valid, vld);
    if (vld != 0) begin
      chk(int'(rdi_slot) == idx/2, "R8", "rdi_slot", rdi_slot, idx/2);
      chk(int'(rdi_level) == idx%2, "R8", "rdi_level", rdi_level, idx%2);
    end
    for (int s = 0; s < NS; s++) begin
      chk(path_ais[s] == m_flag[s][0][0], "R2/R6", "path_ais", path_ais[s], m_flag[s][0]);
      chk(path_rdi[s] == m_flag[s][1][0], "R2/R6", "path_rdi", path_rdi[s], m_flag[s][1]);
      chk(chan_ais[s] == m_flag[s][2][0], "R3/R6", "chan_ais", chan_ais[s], m_flag[s][2]);
      chk(chan_rdi[s] == m_flag[s][3][0], "R3/R6", "chan_rdi", chan_rdi[s], m_flag[s][3]);
    end
    // drive
    cell_valid = v; cell_slot = SW'(slot); cell_vci = 16'(vci); cell_pti = 3'(pti);
    cell_oam_type = 4'(oam); cell_fn_type = 4'(fn); rdi_ready = rdy;
    // reference update
    hs  = (vld != 0 && rdy) ? 1 : 0;
    lvl = (vci == 3 || vci == 4) ? 0 : 1;
    isr = (fn == 1) ? 1 : 0;
    hit = (v && oam == 1 && (fn == 0 || fn == 1) &&
           (lvl == 0 || pti == 4 || pti == 5)) ? 1 : 0;
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 4; k++) begin
        if (hit != 0 && s == slot && k == lvl*2 + isr) begin
          m_flag[s][k] = 1; m_sil[s][k] = 0;
        end else if (tk != 0 && m_flag[s][k] != 0) begin
          if (m_sil[s][k] == CLR - 1) begin m_flag[s][k] = 0; m_sil[s][k] = 0; end
          else m_sil[s][k]++;
        end
      end
    if (hs != 0) m_pend[idx] = 0;
    if (tk != 0)
      for (int s = 0; s < NS; s++) begin
        if (m_flag[s][0] != 0) m_pend[2*s] = 1;
        if (m_flag[s][2] != 0) m_pend[2*s+1] = 1;
      end
    m_lock = (vld != 0 && !rdy) ? 1 : 0;
    m_lock_idx = idx;
    m_tcnt = (tk != 0) ? 0 : m_tcnt + 1;
    n_tick += tk;
    n_hs += hs;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit rdy);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, rdy);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 4; k++) begin m_flag[s][k] = 0; m_sil[s][k] = 0; end
    for (int i = 0; i < 2*NS; i++) m_pend[i] = 0;
    m_lock = 0; m_lock_idx = 0; m_tcnt = 0; n_tick = 0; n_hs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    vectors++;
    chk({path_ais, path_rdi, chan_ais, chan_rdi} == '0, "R1", "flags after reset",
        int'({path_ais, path_rdi, chan_ais, chan_rdi}), 0);
    chk(rdi_valid == 1'b0, "R1", "rdi_valid after reset", rdi_valid, 0);
    chk(sec_tick == 1'b0, "R1", "sec_tick after reset", sec_tick, 0);
    idle(4, 1);

    // R2: path AIS on slot 1 (vci 3), path RDI on slot 0 (vci 4)
    step(1, 1, 3, 0, 1, 0, 1);
    step(1, 0, 4, 0, 1, 1, 1);
    // R3: channel AIS on slot 2 (pti 101), channel RDI on slot 3 (pti 100)
    step(1, 2, 100, 5, 1, 0, 1);
    step(1, 3, 77, 4, 1, 1, 1);
    idle(80, 1);   // R6: flags clear after three silent ticks; R7 requests meanwhile

    // R4: near-miss cells that must be ignored
    step(1, 1, 3, 0, 2, 0, 1);    // wrong OAM type
    step(1, 1, 3, 0, 1, 3, 1);    // unknown function
    step(1, 2, 33, 0, 1, 0, 1);   // user cell PTI 000
    step(1, 2, 33, 6, 1, 0, 1);   // PTI 110
    step(0, 0, 4, 0, 1, 0, 1);    // valid low
    #1;
    vectors++;
    chk({path_ais, path_rdi, chan_ais, chan_rdi} == '0, "R4", "flags after ignored cells",
        int'({path_ais, path_rdi, chan_ais, chan_rdi}), 0);
    chk(rdi_valid == 1'b0, "R4", "request after ignored cells", rdi_valid, 0);
    idle(3, 1);

    // R7: AIS flood on slot 0, both levels, inserter mostly stalled
    sec_div = 16'd8;
    n_tick = 0; n_hs = 0;
    for (int c = 0; c < 160; c++)
      step(1, 0, (c % 2 == 0) ? 3 : 50, 5, 1, 0, (c % 5) == 0);
    vectors++;
    chk(n_hs <= n_tick * 2, "R7", "handshakes vs ticks in flood", n_hs, n_tick * 2);
    idle(60, 1);

    // R5: tick period changes, including 0 and 1
    sec_div = 16'd0;  idle(5, 1);
    sec_div = 16'd1;  idle(5, 1);
    sec_div = 16'd20; idle(10, 1);
    sec_div = 16'd3;  idle(6, 1);

    // R8 and mixed traffic: random cells, random back-pressure, several periods
    for (int ph = 0; ph < 3; ph++) begin
      sec_div = (ph == 0) ? 16'd12 : (ph == 1) ? 16'd5 : 16'd2;
      for (int c = 0; c < 600; c++) begin
        int vsel = $urandom_range(0, 2);
        int psel = $urandom_range(0, 3);
        step($urandom_range(0, 9) < 3, $urandom_range(0, NS - 1),
             (vsel == 0) ? 3 : (vsel == 1) ? 4 : 9,
             (psel == 0) ? 0 : (psel == 1) ? 4 : (psel == 2) ? 5 : 1,
             ($urandom_range(0, 3) == 0) ? 2 : 1,
             $urandom_range(0, 2),
             $urandom_range(0, 9) < 6);
      end
    end
    idle(40, 1);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule